// File: doc/BRIEF.md
# Bus clock speed calibrator

The calibrator works out how fast an unknown bus clock is running. A slow square wave that is derived from that bus clock is sampled on the local clock. The wave's period is measured against a free-running reference counter whose frequency is known. After a start pulse, the block counts rising edges of the sampled wave and throws the first two away. It then takes a reference-counter timestamp on the second edge and another on the edge that closes 256 further full wave cycles.

A sequential restoring divider turns the timestamp span into nanoseconds per wave count tick. One count tick is 520 bus clocks, and the wave toggles every 64 ticks. If the result lies outside the plausible bus-speed window, a default value replaces it and a fallback flag is set. The value that is kept is then sorted into a fast or a slow bus. That choice selects the input clock constant handed to a UART.

A timeout ends a measurement whose final edge never arrives, and the default path is taken. Software or a sequencer pulses the start input once and waits for busy to fall.

Top module: `bcc_calibrator`

## Requirements
- R1: After reset, busy is 0, tick_period_ns is 7878, cal_fail is 0 and uart_clk_hz is 66666667.
- R2: A start pulse seen while busy is 0 raises busy on the next clock edge. Busy falls on the same edge on which tick_period_ns, cal_fail and uart_clk_hz take their new values.
- R3: A rising edge is counted only when the sampled wave level was 0 on the previous sample and 1 on the current one. The previous level is taken as 1 when a measurement starts, so a wave that is already high at start gives no edge.
- R4: The first two counted edges are discarded. The reference count is captured on the 2nd counted edge and again on the 258th, and the span between the two captures is measured.
- R5: The measured tick period is floor(span × 10^9 / (256 × 2 × 64 × REF_HZ)) nanoseconds.
- R6: A measured period above 20800 or below 6933 sets cal_fail to 1 and stores 7878 instead. The values 20800 and 6933 themselves are accepted with cal_fail at 0.
- R7: uart_clk_hz is 66666667 when the stored period divided by 520 is below 20, which means a stored period below 10400. Otherwise it is 33333333.
- R8: If the 258th edge has not arrived within TIMEOUT_CYC cycles of measuring, the run ends with cal_fail 1, tick_period_ns 7878 and uart_clk_hz 66666667.
- R9: While busy is 1, tick_period_ns, cal_fail and uart_clk_hz keep the values of the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a calibration when idle |
| wave_in | input | 1 | Square wave derived from the bus clock |
| ref_count | input | TS_W | Free-running reference counter value |
| busy | output | 1 | High from launch until results are written |
| tick_period_ns | output | RES_W | Stored count tick period in ns |
| cal_fail | output | 1 | Measurement rejected or timed out, default in use |
| uart_clk_hz | output | 32 | Selected UART input clock constant |

## Verification
Busy is due one edge after start, and the bench samples it on the following falling edge. The results appear only when busy falls, which happens about 80 cycles after the closing wave edge because of the divider. For that reason the bench polls busy on falling edges and compares all three outputs in the first sample where busy is low. For the hold check, it samples the outputs in the middle of a run. The wave the bench drives starts high and has an irregular first period. A wrong edge definition or a wrong discard count therefore changes the timestamp span and shows up as a wrong period. The timeout is checked with a window: busy must still be high shortly before TIMEOUT_CYC and must be low a little after it.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int UART_W       = 32;
    localparam int NS_PER_S     = 1_000_000_000;
    localparam int UART_FAST_HZ = 66_666_667;
    localparam int UART_SLOW_HZ = 33_333_333;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DIV  = 2'd2
    } bcc_state_e;

    // nanoseconds per tick for a bus clock of mhz megahertz
    function automatic int tick_ns_for_mhz(input int ticks_per_count, input int mhz);
        return (1000 * ticks_per_count) / mhz;
    endfunction

endpackage

// File: rtl/bcc_edge_timer.sv
module bcc_edge_timer #(
    parameter int TS_W          = 48,
    parameter int DISCARD_EDGES = 2,
    parameter int MEASURE_EDGES = 256,
    parameter int TIMEOUT_CYC   = 16777216
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            wave_in,
    input  logic [TS_W-1:0] ref_count,
    output logic            done_o,
    output logic            timeout_o,
    output logic [TS_W-1:0] span_o
);
    localparam int END_EDGE = DISCARD_EDGES + MEASURE_EDGES;
    localparam int CNT_W    = $clog2(END_EDGE + 1);
    localparam int TO_W     = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] FIRST_AT = CNT_W'(DISCARD_EDGES);
    localparam logic [CNT_W-1:0] LAST_AT  = CNT_W'(END_EDGE);
    localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic             active;
        logic             lvl;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [TO_W-1:0]  tmo;
        logic [TS_W-1:0]  t0;
        logic [TS_W-1:0]  span;
        logic             done;
        logic             to;
    } et_t;

    et_t et_d, et_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        et_d    = et_q;
        et_d.done = 1'b0;
        et_d.to   = 1'b0;
        et_d.lvl  = wave_in;
        rise    = !et_q.prev && et_q.lvl;
        cnt_inc = et_q.cnt + 1'b1;
        if (go) begin
            et_d.active = 1'b1;
            et_d.prev   = 1'b1;
            et_d.cnt    = '0;
            et_d.tmo    = '0;
        end else if (et_q.active) begin
            et_d.prev = et_q.lvl;
            et_d.tmo  = et_q.tmo + 1'b1;
            if (rise) begin
                et_d.cnt = cnt_inc;
                if (cnt_inc == FIRST_AT) begin
                    et_d.t0 = ref_count;
                end
                if (cnt_inc == LAST_AT) begin
                    et_d.span   = ref_count - et_q.t0;
                    et_d.done   = 1'b1;
                    et_d.active = 1'b0;
                end
            end
            if (!et_d.done && et_q.tmo == TO_LAST) begin
                et_d.to     = 1'b1;
                et_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            et_q      <= '0;
            et_q.lvl  <= 1'b1;
            et_q.prev <= 1'b1;
        end else begin
            et_q <= et_d;
        end
    end

    assign done_o    = et_q.done;
    assign timeout_o = et_q.to;
    assign span_o    = et_q.span;

endmodule

// File: rtl/bcc_divider.sv
module bcc_divider #(
    parameter int NUM_W = 78,
    parameter int DEN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int IT_W = $clog2(NUM_W + 1);
    localparam logic [IT_W-1:0] IT_LAST = IT_W'(NUM_W - 1);

    typedef struct packed {
        logic             run;
        logic [DEN_W:0]   rem;
        logic [NUM_W-1:0] quo;
        logic [IT_W-1:0]  it;
        logic             done;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [DEN_W:0] shifted;
    logic           take;

    always_comb begin
        dv_d = dv_q;
        dv_d.done = 1'b0;
        shifted = {dv_q.rem[DEN_W-1:0], dv_q.quo[NUM_W-1]};
        take    = shifted >= {1'b0, den};
        if (load) begin
            dv_d.run = 1'b1;
            dv_d.rem = '0;
            dv_d.quo = num;
            dv_d.it  = '0;
        end else if (dv_q.run) begin
            dv_d.rem = take ? (shifted - {1'b0, den}) : shifted;
            dv_d.quo = {dv_q.quo[NUM_W-2:0], take};
            dv_d.it  = dv_q.it + 1'b1;
            if (dv_q.it == IT_LAST) begin
                dv_d.run  = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done_o = dv_q.done;
    assign quo_o  = dv_q.quo;

endmodule

// File: rtl/bcc_judge.sv
module bcc_judge
    import bcc_pkg::*;
#(
    parameter int NUM_W      = 78,
    parameter int RES_W      = 32,
    parameter int LIMIT_SLOW = 20800,
    parameter int LIMIT_FAST = 6933,
    parameter int DEFAULT_NS = 7878,
    parameter int FAST_BELOW = 10400
) (
    input  logic [NUM_W-1:0]  quo,
    input  logic              force_fail,
    output logic [RES_W-1:0]  period,
    output logic              fail,
    output logic [UART_W-1:0] uart_hz
);
    logic in_range;

    always_comb begin
        in_range = (quo <= NUM_W'(LIMIT_SLOW)) && (quo >= NUM_W'(LIMIT_FAST));
        fail     = force_fail || !in_range;
        period   = fail ? RES_W'(DEFAULT_NS) : quo[RES_W-1:0];
        uart_hz  = (period < RES_W'(FAST_BELOW)) ? UART_W'(UART_FAST_HZ)
                                                 : UART_W'(UART_SLOW_HZ);
    end

endmodule

// File: rtl/bcc_calibrator.sv
module bcc_calibrator
    import bcc_pkg::*;
#(
    parameter int REF_HZ        = 25_000_000,
    parameter int TS_W          = 48,
    parameter int RES_W         = 32,
    parameter int WAVE_COUNT    = 63,
    parameter int TICK_DIV      = 520,
    parameter int DISCARD_EDGES = 2,
    parameter int MEASURE_EDGES = 256,
    parameter int LOW_MHZ       = 25,
    parameter int HIGH_MHZ      = 75,
    parameter int DEFAULT_MHZ   = 66,
    parameter int FAST_NS       = 20,
    parameter int TIMEOUT_CYC   = 16777216
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wave_in,
    input  logic [TS_W-1:0]   ref_count,
    output logic              busy,
    output logic [RES_W-1:0]  tick_period_ns,
    output logic              cal_fail,
    output logic [UART_W-1:0] uart_clk_hz
);
    localparam int NUM_W      = TS_W + 30;
    localparam int DEN_W      = 64;
    localparam logic [DEN_W-1:0] DEN_VAL =
        64'(MEASURE_EDGES) * 64'(2 * (WAVE_COUNT + 1)) * 64'(REF_HZ);
    localparam int LIMIT_SLOW = tick_ns_for_mhz(TICK_DIV, LOW_MHZ);
    localparam int LIMIT_FAST = tick_ns_for_mhz(TICK_DIV, HIGH_MHZ);
    localparam int DEFAULT_NS = tick_ns_for_mhz(TICK_DIV, DEFAULT_MHZ);
    localparam int FAST_BELOW = FAST_NS * TICK_DIV;

    typedef struct packed {
        bcc_state_e        st;
        logic              busy;
        logic [RES_W-1:0]  period;
        logic              fail;
        logic [UART_W-1:0] uart;
    } top_t;

    top_t tp_d, tp_q;

    logic              et_go, et_done, et_to;
    logic [TS_W-1:0]   et_span;
    logic              dv_load, dv_done;
    logic [NUM_W-1:0]  dv_num, dv_quo;
    logic              jg_force;
    logic [RES_W-1:0]  jg_period;
    logic              jg_fail;
    logic [UART_W-1:0] jg_uart;

    bcc_edge_timer #(
        .TS_W(TS_W), .DISCARD_EDGES(DISCARD_EDGES),
        .MEASURE_EDGES(MEASURE_EDGES), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_edge (
        .clk(clk), .rst_n(rst_n), .go(et_go), .wave_in(wave_in),
        .ref_count(ref_count), .done_o(et_done), .timeout_o(et_to),
        .span_o(et_span)
    );

    assign dv_num = NUM_W'(et_span) * NUM_W'(NS_PER_S);

    bcc_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(dv_load), .num(dv_num),
        .den(DEN_VAL), .done_o(dv_done), .quo_o(dv_quo)
    );

    bcc_judge #(
        .NUM_W(NUM_W), .RES_W(RES_W), .LIMIT_SLOW(LIMIT_SLOW),
        .LIMIT_FAST(LIMIT_FAST), .DEFAULT_NS(DEFAULT_NS), .FAST_BELOW(FAST_BELOW)
    ) u_judge (
        .quo(dv_quo), .force_fail(jg_force), .period(jg_period),
        .fail(jg_fail), .uart_hz(jg_uart)
    );

    always_comb begin
        tp_d     = tp_q;
        et_go    = 1'b0;
        dv_load  = 1'b0;
        jg_force = (tp_q.st == ST_MEAS);
        case (tp_q.st)
            ST_IDLE: begin
                if (start) begin
                    tp_d.st   = ST_MEAS;
                    tp_d.busy = 1'b1;
                    et_go     = 1'b1;
                end
            end
            ST_MEAS: begin
                if (et_done) begin
                    dv_load = 1'b1;
                    tp_d.st = ST_DIV;
                end else if (et_to) begin
                    tp_d.st     = ST_IDLE;
                    tp_d.busy   = 1'b0;
                    tp_d.period = jg_period;
                    tp_d.fail   = jg_fail;
                    tp_d.uart   = jg_uart;
                end
            end
            ST_DIV: begin
                if (dv_done) begin
                    tp_d.st     = ST_IDLE;
                    tp_d.busy   = 1'b0;
                    tp_d.period = jg_period;
                    tp_d.fail   = jg_fail;
                    tp_d.uart   = jg_uart;
                end
            end
            default: tp_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q.st     <= ST_IDLE;
            tp_q.busy   <= 1'b0;
            tp_q.period <= RES_W'(DEFAULT_NS);
            tp_q.fail   <= 1'b0;
            tp_q.uart   <= UART_W'(UART_FAST_HZ);
        end else begin
            tp_q <= tp_d;
        end
    end

    assign busy           = tp_q.busy;
    assign tick_period_ns = tp_q.period;
    assign cal_fail       = tp_q.fail;
    assign uart_clk_hz    = tp_q.uart;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
    import bcc_pkg::*;
#(
    parameter int RES_W      = 32,
    parameter int LIMIT_SLOW = 20800,
    parameter int LIMIT_FAST = 6933,
    parameter int DEFAULT_NS = 7878,
    parameter int FAST_BELOW = 10400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [RES_W-1:0]  tick_period_ns,
    input logic              cal_fail,
    input logic [UART_W-1:0] uart_clk_hz
);
    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(tick_period_ns) && $stable(cal_fail) && $stable(uart_clk_hz))));

    assert_period_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tick_period_ns <= RES_W'(LIMIT_SLOW) && tick_period_ns >= RES_W'(LIMIT_FAST)));

    assert_fail_uses_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cal_fail) |-> (tick_period_ns == RES_W'(DEFAULT_NS)));

    assert_uart_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (uart_clk_hz == ((tick_period_ns < RES_W'(FAST_BELOW)) ?
                   UART_W'(UART_FAST_HZ) : UART_W'(UART_SLOW_HZ))));

endmodule

bind bcc_calibrator bcc_checker #(
    .RES_W(RES_W), .LIMIT_SLOW(LIMIT_SLOW), .LIMIT_FAST(LIMIT_FAST),
    .DEFAULT_NS(DEFAULT_NS), .FAST_BELOW(FAST_BELOW)
) u_bcc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .tick_period_ns(tick_period_ns), .cal_fail(cal_fail), .uart_clk_hz(uart_clk_hz)
);

// File: tb/bcc_calibrator_bench.sv
module bcc_calibrator_bench;
    localparam int TS_W    = 48;
    localparam int TMO     = 8000;
    localparam int WAVE_HI = 10;
    localparam int WAVE_LO = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            wave_in = 1'b1;
    logic [TS_W-1:0] ref_count = '0;
    logic            busy;
    logic [31:0]     tick_period_ns;
    logic            cal_fail;
    logic [31:0]     uart_clk_hz;

    int  total = 0;
    int  bad = 0;
    int  step = 1;
    longint last_period = 7878;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) ref_count <= '0;
        else        ref_count <= ref_count + TS_W'(step);
    end

    bcc_calibrator #(.TIMEOUT_CYC(TMO)) u_bcc_calibrator (
        .clk(clk), .rst_n(rst_n), .start(start), .wave_in(wave_in),
        .ref_count(ref_count), .busy(busy), .tick_period_ns(tick_period_ns),
        .cal_fail(cal_fail), .uart_clk_hz(uart_clk_hz)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        hold(1);
        start = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (!busy) break;
            hold(1);
        end
    endtask

    // R3 R4 R5 R6 R7: one full calibration with reference step s per clock
    task automatic run_meas(input int s, input string tag);
        longint span, meas, expp, expu;
        bit expf;
        step = s;
        wave_in = 1'b1;
        hold(3);
        pulse_start();
        chk("R2", {tag, " busy after start"}, longint'(busy), 1);
        hold(6);                       // high at start: not an edge (R3)
        wave_in = 1'b0; hold(13);
        wave_in = 1'b1; hold(25);      // edge 1, irregular period
        wave_in = 1'b0; hold(25);
        wave_in = 1'b1;                // edge 2: start timestamp (R4)
        for (int i = 0; i < MEAS_LOOPS; i++) begin
            hold(WAVE_HI); wave_in = 1'b0;
            hold(WAVE_LO); wave_in = 1'b1;
            if (i == 100) begin
                chk("R9", {tag, " busy mid-run"}, longint'(busy), 1);
                chk("R9", {tag, " period held"}, longint'(tick_period_ns), last_period);
            end
        end
        wait_idle(400);
        span = 256 * (WAVE_HI + WAVE_LO) * longint'(s);
        meas = (span * 64'd1_000_000_000) / (64'd32768 * 64'd25_000_000);
        expf = (meas > 20800) || (meas < 6933);
        expp = expf ? 7878 : meas;
        expu = (expp < 10400) ? 66666667 : 33333333;
        chk("R2", {tag, " busy low"}, longint'(busy), 0);
        chk("R5 R6", {tag, " period"}, longint'(tick_period_ns), expp);
        chk("R6", {tag, " fail flag"}, longint'(cal_fail), longint'(expf));
        chk("R7", {tag, " uart clock"}, longint'(uart_clk_hz), expu);
        last_period = expp;
    endtask

    localparam int MEAS_LOOPS = 259;

    // R8: wave never toggles
    task automatic run_timeout();
        wave_in = 1'b0;
        hold(3);
        pulse_start();
        hold(TMO - 100);
        chk("R8", "busy before timeout", longint'(busy), 1);
        wait_idle(300);
        chk("R8", "busy after timeout", longint'(busy), 0);
        chk("R8", "timeout fail flag", longint'(cal_fail), 1);
        chk("R8", "timeout period", longint'(tick_period_ns), 7878);
        chk("R8", "timeout uart", longint'(uart_clk_hz), 66666667);
        last_period = 7878;
    endtask

    initial begin
        hold(3);
        chk("R1", "reset busy", longint'(busy), 0);
        chk("R1", "reset period", longint'(tick_period_ns), 7878);
        chk("R1", "reset fail", longint'(cal_fail), 0);
        chk("R1", "reset uart", longint'(uart_clk_hz), 66666667);
        rst_n = 1'b1;
        hold(3);
        run_meas(1248, "66MHz");
        run_meas(2400, "33MHz");
        run_meas(1000, "too fast");
        run_meas(3328, "slow edge 20800");
        run_meas(4000, "too slow");
        run_meas(1110, "fast edge 6937");
        run_meas(1109, "below 6933");
        run_meas(1664, "class 10400");
        run_meas(1663, "class 10393");
        run_timeout();
        run_meas(2400, "recover");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule